// File: doc/BRIEF.md
# Relocatable Peripheral Base Decoder

This block holds a privileged base register that places a 4-Kbyte window of on-chip peripheral registers at any 4-Kbyte-aligned spot in a 32-bit address space. For each bus request it picks one target: the peripheral window, on-chip SRAM or cache, a chip-select region, or the external bus. The SRAM and chip-select hit flags come from outside, and the block combines them with its own window match under a fixed priority.

The window only matches when the register's enable bit is set and the access type is not masked. Access types are user data, user code, supervisor data, supervisor code and CPU-space/interrupt-acknowledge. A masked access is decoded as if the window did not exist. A protect bit blocks writes into the window. The processor may write the register only in supervisor mode and cannot read it. A debug port can both read and write it.

Top module: `periph_base_decoder`

## Requirements
- R1: After reset the enable bit (register bit 0) reads 0, and while it is 0 no request selects the peripheral window.
- R2: With the enable bit set, a request hits the window exactly when address bits 31:12 equal register bits 31:12.
- R3: With the attribute-mask control (bit 6) set, a type whose mask bit is 1 never hits the window. The mask bits are: user data bit 1, user code bit 2, supervisor data bit 3, supervisor code bit 4, CPU-space bit 5. A mask bit of 0 lets the type through. Such a request is decoded by the remaining priority.
- R4: With the attribute-mask control clear, the five mask bits have no effect on decoding.
- R5: Priority is window first, then SRAM/cache (`sram_hit`), then chip select (`cs_hit`), then external bus.
- R6: With `req_valid` low all four selects are 0. With `req_valid` high exactly one select is 1, except for a write blocked under R10.
- R7: A supervisor processor write updates the register on the next clock edge. A request in the same cycle is decoded with the old value.
- R8: A processor write with `cpu_super` low leaves the register unchanged, and `err` is 1 for the following cycle.
- R9: `dbg_rdata` returns the register with bits 11:9 and 7 as zero. When the debug port and the processor write in the same cycle, the debug value is stored.
- R10: With the protect bit (bit 8) set, a write that hits the window drives all selects to 0, and `err` is 1 in the following cycle. Reads in the window are unaffected.
- R11: Access-type codes are: 0 user data, 1 user code, 2 supervisor data, 3 supervisor code, 4 CPU space. Codes 5 to 7 never hit the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor register write strobe |
| cpu_super | input | 1 | Processor is in supervisor mode |
| cpu_wdata | input | 32 | Processor write data |
| dbg_wr_en | input | 1 | Debug register write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read of the register |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| req_space | input | 3 | Access-type code (R11) |
| sram_hit | input | 1 | Address hits SRAM or cache |
| cs_hit | input | 1 | Address hits a chip-select region |
| sel_periph | output | 1 | Request goes to the peripheral window |
| sel_sram | output | 1 | Request goes to SRAM/cache |
| sel_cs | output | 1 | Request goes to chip select |
| sel_ext | output | 1 | Request goes to the external bus |
| err | output | 1 | One-cycle error pulse (R8, R10) |

## Verification
Two things can happen in the same cycle: a register write and a decode that depends on the register. The bench writes a new base and enable in one cycle while it presents an address in the new window. It expects the old routing in that cycle and the window hit one cycle later. It also raises a user-mode write together with a protected window write, and a debug write together with a processor write. The bench judges each pairing with a behavioural model compared on every clock: a single error pulse for the first, and the debug value stored for the second.

// File: rtl/periph_base_decoder.sv
module periph_base_decoder #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic          cpu_super,
  input  logic [AW-1:0] cpu_wdata,
  input  logic          dbg_wr_en,
  input  logic [AW-1:0] dbg_wdata,
  output logic [AW-1:0] dbg_rdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [2:0]    req_space,
  input  logic          sram_hit,
  input  logic          cs_hit,
  output logic          sel_periph,
  output logic          sel_sram,
  output logic          sel_cs,
  output logic          sel_ext,
  output logic          err
);
  localparam int PG = 12;

  logic [AW-1:PG] base_q;
  logic           en_q, prot_q, amask_q;
  logic [4:0]     tmask_q;

  logic          load, user_try, win, prot_blk;
  logic [AW-1:0] wdata;
  logic [7:0]    blocked_type;

  assign load     = dbg_wr_en | (cpu_wr_en & cpu_super);
  assign user_try = cpu_wr_en & ~cpu_super;
  assign wdata    = dbg_wr_en ? dbg_wdata : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else if (load) en_q <= wdata[0];

  always_ff @(posedge clk)
    if (load) begin
      base_q  <= wdata[AW-1:PG];
      prot_q  <= wdata[8];
      amask_q <= wdata[6];
      tmask_q <= wdata[5:1];
    end

  assign dbg_rdata = {base_q, 3'b000, prot_q, 1'b0, amask_q, tmask_q, en_q};

  assign blocked_type = {3'b111, amask_q ? tmask_q : 5'b00000};
  assign win      = req_valid & en_q & (req_addr[AW-1:PG] == base_q) & ~blocked_type[req_space];
  assign prot_blk = win & req_write & prot_q;

  assign sel_periph = win & ~prot_blk;
  assign sel_sram   = req_valid & ~win & sram_hit;
  assign sel_cs     = req_valid & ~win & ~sram_hit & cs_hit;
  assign sel_ext    = req_valid & ~win & ~sram_hit & ~cs_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= 1'b0;
    else err <= user_try | prot_blk;

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_periph, sel_sram, sel_cs, sel_ext}));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(sel_periph | sel_sram | sel_cs | sel_ext));
  assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rdata[0] |-> !sel_periph);
  assert_user_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (user_try && !dbg_wr_en) |=> (err && $stable(dbg_rdata)));
  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_periph && req_write) |-> !dbg_rdata[8]);
  assert_protect_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && dbg_rdata[8] && dbg_rdata[0] && !sel_periph &&
     !sel_sram && !sel_cs && !sel_ext) |=> err);
endmodule

// File: tb/tb_periph_base_decoder.sv
module tb_periph_base_decoder;
  logic clk = 0, rst_n = 0;
  logic cpu_wr_en = 0, cpu_super = 0, dbg_wr_en = 0;
  logic [31:0] cpu_wdata = 0, dbg_wdata = 0, req_addr = 0;
  logic req_valid = 0, req_write = 0, sram_hit = 0, cs_hit = 0;
  logic [2:0] req_space = 0;
  logic [31:0] dbg_rdata;
  logic sel_periph, sel_sram, sel_cs, sel_ext, err;

  periph_base_decoder dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit known = 0;
  bit [31:0] mreg = 0;
  bit exp_err = 0;
  string tag = "R6";

  function automatic bit [3:0] model_sel();
    bit hit;
    int mb;
    if (!req_valid) return 4'b0000;
    hit = mreg[0] && (req_addr[31:12] == mreg[31:12]);
    if (req_space > 4) hit = 0;
    else begin
      mb = req_space + 1;
      if (mreg[6] && mreg[mb]) hit = 0;
    end
    if (hit) return (req_write && mreg[8]) ? 4'b0000 : 4'b1000;
    if (sram_hit) return 4'b0100;
    if (cs_hit) return 4'b0010;
    return 4'b0001;
  endfunction

  task automatic check(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit [3:0] s;
    bit hit_blk;
    @(negedge clk);
    s = model_sel();
    check(tag, "sel", {28'd0, sel_periph, sel_sram, sel_cs, sel_ext}, {28'd0, s});
    check(tag, "err", {31'd0, err}, {31'd0, exp_err});
    if (known) check(tag, "rdata", dbg_rdata, mreg);
    else check(tag, "enable", {31'd0, dbg_rdata[0]}, {31'd0, mreg[0]});
    @(posedge clk);
    hit_blk = req_valid && req_write && mreg[8] && mreg[0] &&
              (req_addr[31:12] == mreg[31:12]) && req_space <= 4 &&
              !(mreg[6] && mreg[req_space + 1]);
    exp_err = (cpu_wr_en && !cpu_super) || hit_blk;
    if (dbg_wr_en) begin mreg = dbg_wdata & 32'hFFFF_F17F; known = 1; end
    else if (cpu_wr_en && cpu_super) begin mreg = cpu_wdata & 32'hFFFF_F17F; known = 1; end
    #1;
    cpu_wr_en = 0; dbg_wr_en = 0;
  endtask

  task automatic req(logic [31:0] a, logic w, logic [2:0] sp, logic s, logic c);
    req_valid = 1; req_addr = a; req_write = w; req_space = sp; sram_hit = s; cs_hit = c;
    cycle();
  endtask

  task automatic cpu_write(logic [31:0] d, logic sup);
    cpu_wr_en = 1; cpu_super = sup; cpu_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    req(32'h0000_0000, 0, 3, 0, 0);
    req(32'h0000_0000, 0, 3, 1, 1);
    tag = "R6"; req_valid = 0; sram_hit = 1; cycle();

    tag = "R7";
    cpu_write(32'h4000_0001, 1);
    req(32'h4000_0010, 0, 3, 0, 1);
    req(32'h4000_0010, 0, 3, 0, 1);

    tag = "R2";
    req(32'h4000_0FFF, 0, 2, 0, 0);
    req(32'h4000_1000, 0, 2, 0, 0);
    req(32'h3FFF_FFFC, 1, 0, 0, 0);

    tag = "R5";
    req(32'h4000_0004, 0, 2, 1, 1);
    req(32'h5000_0004, 0, 2, 1, 1);
    req(32'h5000_0004, 0, 2, 0, 1);
    req(32'h5000_0004, 0, 2, 0, 0);

    tag = "R4";
    cpu_write(32'h4000_003F, 1); cycle();
    for (int sp = 0; sp < 8; sp++) begin
      tag = (sp > 4) ? "R11" : "R4";
      req(32'h4000_0100, 0, sp[2:0], 1, 0);
    end
    for (int b = 1; b <= 5; b++) begin
      tag = "R3";
      cpu_write(32'h4000_0041 | (32'd1 << b), 1); cycle();
      for (int sp = 0; sp < 8; sp++) begin
        tag = (sp > 4) ? "R11" : "R3";
        req(32'h4000_0200, 0, sp[2:0], sp[0], 1);
      end
    end

    tag = "R8";
    cpu_write(32'h9000_0001, 0);
    req(32'h4000_0000, 0, 3, 0, 0);
    req(32'h9000_0000, 0, 3, 0, 0);
    req(32'h4000_0000, 0, 3, 0, 0);

    tag = "R9";
    dbg_wr_en = 1; dbg_wdata = 32'hFFFF_FFFF;
    cpu_write(32'h1234_5001, 1);
    cycle(); cycle();
    dbg_wr_en = 1; dbg_wdata = 32'hA000_0001; cycle(); cycle();

    tag = "R10";
    cpu_write(32'hA000_0101, 1); cycle();
    req(32'hA000_0008, 1, 3, 1, 1);
    req(32'hA000_0008, 0, 3, 1, 1);
    cpu_write(32'h0000_0000, 0);
    req(32'hA000_0008, 1, 2, 0, 0);
    req(32'hB000_0008, 1, 2, 0, 0);
    req(32'hB000_0008, 0, 2, 0, 0);

    tag = "R6";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [3:0] r;
      r = 4'($urandom);
      a = (r[0] ? 32'hA000_0000 : 32'($urandom)) | (32'($urandom) & 32'h0000_1FFF);
      if (r[3:1] == 0) cpu_write(32'($urandom) | 32'h1, r[1]);
      if (i % 37 == 0) begin dbg_wr_en = 1; dbg_wdata = 32'hA000_0001 | (32'($urandom) & 32'h17E); end
      req_valid = (r != 4'hF); req_addr = a; req_write = r[2];
      req_space = 3'($urandom); sram_hit = r[3]; cs_hit = r[1];
      cycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule